// File: doc/BRIEF.md
# Hamming Sector ECC Corrector

This block sits behind a flash read path and checks one 512-byte data sector against its 24-bit Hamming code. Software or an upstream engine loads the sector bytes through a write port. It then presents two codes: the code read back from the page's spare area and the code computed while the data streamed in. A start pulse launches the check.

The block rearranges each 3-byte code into a 32-bit word and XORs the two words. It counts the set bits of the difference and classifies the sector into one of four results. When exactly one data bit is wrong, the block repairs the byte in its own buffer with a read-modify-write before it reports completion. The corrected sector is then drained through a combinational read port.

An erased page gives an all-ones stored code and an all-zeros computed code. This pattern is recognised and reported as clean rather than as an error.

Top module: `hamming_sector_fixer`

## Requirements
- R1: Each code input carries byte 0 in bits 7:0, byte 1 in bits 15:8 and byte 2 in bits 23:16. A code is repacked to a word with byte 0 in bits 7:0, byte 1 in bits 23:16, the upper nibble of byte 2 in bits 27:24 and its lower nibble in bits 11:8. Equal stored and computed words finish with status 0 (clean) and leave the buffer unchanged.
- R2: A word difference with exactly 12 set bits finishes with status 1 (corrected). The buffer byte addressed by difference bits 27:19 has the bit numbered by difference bits 18:16 inverted, and no other byte changes.
- R3: A word difference with exactly one set bit finishes with status 2 (code corrupted) and leaves the buffer unchanged.
- R4: A stored code of 0xFFFFFF with a computed code of 0x000000 (erased page) finishes with status 0 and leaves the buffer unchanged.
- R5: Any other nonzero difference finishes with status 3 (uncorrectable) and leaves the buffer unchanged.
- R6: busy rises on the cycle after an accepted start. done is a single-cycle pulse issued on the cycle in which busy falls.
- R7: A start asserted while busy is ignored: it yields no extra done pulse and does not alter the result of the check in progress.
- R8: Writes to the sector buffer are ignored while busy.
- R9: After reset, busy, done and status are all 0.
- R10: status changes only together with a done pulse and otherwise holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Buffer byte write strobe |
| wr_addr | input | ADDR_W | Buffer write byte address |
| wr_data | input | 8 | Buffer write byte |
| stored_code | input | 24 | Code read from the spare area |
| calc_code | input | 24 | Code computed over the data |
| start | input | 1 | Launch a check |
| busy | output | 1 | Check in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 clean, 1 corrected, 2 code corrupted, 3 uncorrectable |
| rd_addr | input | ADDR_W | Buffer read byte address |
| rd_data | output | 8 | Buffer byte at rd_addr |

## Verification
The case hardest to reach from the ports is a legitimate single-bit error that lands on the extreme byte and bit positions. Reaching it requires a difference whose upper 12-bit field is the error address and whose lower field is its complement. The stimulus builds this difference, scatters it back into the three code bytes, and masks it with an unrelated computed code. The erased pattern and a one-bit deviation from it are also driven, so the bench can separate the special case from the general count.

// File: rtl/hamming_sector_fixer.sv
module hamming_sector_fixer #(
  parameter int SECTOR_BYTES = 512,
  parameter int ADDR_W = $clog2(SECTOR_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [23:0]       stored_code,
  input  logic [23:0]       calc_code,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic [1:0]        status,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int WORD_W = 32;
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam logic [WORD_W-1:0] ERASED_WORD = 32'h0FFF_0FFF;

  typedef enum logic [2:0] {S_IDLE, S_DIFF, S_CLASS, S_FETCH, S_STORE} state_t;

  function automatic logic [WORD_W-1:0] repack(input logic [23:0] c);
    return {4'h0, c[23:20], c[15:8], 4'h0, c[19:16], c[7:0]};
  endfunction

  function automatic logic [CNT_W-1:0] ones(input logic [WORD_W-1:0] w);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < WORD_W; i++) n = n + CNT_W'(w[i]);
    return n;
  endfunction

  state_t            state;
  logic [WORD_W-1:0] stored_q, calc_q, diff_q;
  logic [CNT_W-1:0]  ones_q;
  logic              erased_q;
  logic [ADDR_W-1:0] fix_addr;
  logic [2:0]        fix_bit;
  logic [7:0]        rmw_q;
  logic [7:0]        mem [SECTOR_BYTES];

  assign busy    = (state != S_IDLE);
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (state == S_STORE)
      mem[fix_addr] <= rmw_q ^ (8'h01 << fix_bit);
    else if (wr_en && state == S_IDLE)
      mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      stored_q <= '0;
      calc_q   <= '0;
      diff_q   <= '0;
      ones_q   <= '0;
      erased_q <= 1'b0;
      fix_addr <= '0;
      fix_bit  <= '0;
      rmw_q    <= '0;
      done     <= 1'b0;
      status   <= 2'd0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          stored_q <= repack(stored_code);
          calc_q   <= repack(calc_code);
          state    <= S_DIFF;
        end
        S_DIFF: begin
          diff_q   <= stored_q ^ calc_q;
          ones_q   <= ones(stored_q ^ calc_q);
          erased_q <= (stored_q == ERASED_WORD) && (calc_q == '0);
          state    <= S_CLASS;
        end
        S_CLASS: begin
          if (diff_q == '0 || erased_q) begin
            status <= 2'd0;
            done   <= 1'b1;
            state  <= S_IDLE;
          end else if (ones_q == CNT_W'(12)) begin
            fix_addr <= ADDR_W'(diff_q[27:19]);
            fix_bit  <= diff_q[18:16];
            state    <= S_FETCH;
          end else begin
            status <= (ones_q == CNT_W'(1)) ? 2'd2 : 2'd3;
            done   <= 1'b1;
            state  <= S_IDLE;
          end
        end
        S_FETCH: begin
          rmw_q <= mem[fix_addr];
          state <= S_STORE;
        end
        S_STORE: begin
          status <= 2'd1;
          done   <= 1'b1;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hamming_sector_fixer_checker.sv
module hamming_sector_fixer_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic [1:0] status
);
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_fall_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_start_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy || done));
  assert_status_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(status));
endmodule

bind hamming_sector_fixer hamming_sector_fixer_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .status(status)
);

// File: tb/hamming_sector_fixer_bench.sv
module hamming_sector_fixer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 512;
  localparam int AW = 9;
  localparam int NV = 9;
  // {stored, calc, status, fix, byte, bit}
  localparam logic [62:0] VEC [NV] = '{
    {24'h123456, 24'h123456, 2'd0, 1'b0, 9'd0,   3'd0},
    {24'h0F2BD4, 24'h000000, 2'd1, 1'b1, 9'd5,   3'd3},
    {24'hFAF40C, 24'h0A0B0C, 2'd1, 1'b1, 9'd511, 3'd7},
    {24'h0F00FF, 24'h000000, 2'd1, 1'b1, 9'd0,   3'd0},
    {24'h000001, 24'h000000, 2'd2, 1'b0, 9'd0,   3'd0},
    {24'h800000, 24'h000000, 2'd2, 1'b0, 9'd0,   3'd0},
    {24'hFFFFFF, 24'h000000, 2'd0, 1'b0, 9'd0,   3'd0},
    {24'hFFFFFF, 24'h000001, 2'd3, 1'b0, 9'd0,   3'd0},
    {24'h000003, 24'h000000, 2'd3, 1'b0, 9'd0,   3'd0}
  };

  logic clk = 0, rst_n = 0, wr_en = 0, start = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic [23:0] stored_code = '0, calc_code = '0;
  logic busy, done;
  logic [1:0] status;
  logic [7:0] exp_mem [NB];
  int checks = 0, errs = 0, dones = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hamming_sector_fixer u_hamming_sector_fixer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .stored_code(stored_code), .calc_code(calc_code), .start(start),
    .busy(busy), .done(done), .status(status), .rd_addr(rd_addr), .rd_data(rd_data));

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic load_sector(input int seed);
    for (int i = 0; i < NB; i++) begin
      @(negedge clk);
      wr_en = 1; wr_addr = AW'(i); wr_data = 8'(i * 37 + seed);
      exp_mem[i] = 8'(i * 37 + seed);
    end
    @(negedge clk) wr_en = 0;
  endtask

  task automatic check_sector(input string req);
    int bad = 0, first_a = 0, first_v = 0;
    for (int i = 0; i < NB; i++) begin
      rd_addr = AW'(i); #1;
      if (rd_data !== exp_mem[i]) begin
        if (bad == 0) begin first_a = i; first_v = rd_data; end
        bad++;
      end
    end
    check({req, " sector mismatches"}, bad, 0);
    if (bad != 0) $display("  first at byte %0d value %0h expected %0h", first_a, first_v, exp_mem[first_a]);
  endtask

  task automatic wait_done(input string req);
    int cyc = 0;
    while (!done && cyc < 50) begin @(negedge clk); cyc++; end
    check({req, " done seen"}, done, 1);
  endtask

  always @(posedge clk) if (done) dones++;

  initial begin
    #(CLK_PERIOD * 200000);
    errs++; checks++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 busy", busy, 0); check("R9 done", done, 0); check("R9 status", status, 0);
    rst_n = 1;
    for (int v = 0; v < NV; v++) begin
      logic [62:0] e;
      e = VEC[v];
      load_sector(v * 13 + 5);
      @(negedge clk);
      stored_code = e[62:39]; calc_code = e[38:15]; start = 1;
      @(negedge clk); start = 0;
      check("R6 busy after start", busy, 1);
      wait_done("R6");
      // R1 R2 R3 R4 R5 status by class
      check($sformatf("R1-class status vector %0d (R1 R2 R3 R4 R5)", v), status, e[14:13]);
      @(negedge clk);
      check("R6 done single cycle", done, 0);
      if (e[12]) exp_mem[e[11:3]] = exp_mem[e[11:3]] ^ (8'h01 << e[2:0]);
      check_sector($sformatf("R2/R3/R4/R5 vector %0d", v));
    end
    // R10 status holds while idle and across buffer writes
    load_sector(99);
    check("R10 status held", status, 3);
    // R7 and R8: start and write during busy
    @(negedge clk);
    stored_code = 24'h0F2BD4; calc_code = 24'h0; start = 1;
    @(negedge clk);
    dones = 0;
    stored_code = 24'h000001; start = 1;
    wr_en = 1; wr_addr = 9'd100; wr_data = ~exp_mem[100];
    @(negedge clk); start = 0; wr_en = 0;
    wait_done("R7");
    check("R7 status from first start", status, 1);
    repeat (10) @(negedge clk);
    check("R7 single done pulse", dones, 1);
    check("R7 busy idle after", busy, 0);
    exp_mem[5] = exp_mem[5] ^ 8'h08;
    rd_addr = 9'd100; #1;
    check("R8 write ignored while busy", rd_data, exp_mem[100]);
    check_sector("R7 R8 single flip");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule